// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single line that rests high. A one-entry holding register accepts a write whenever it is empty. When transmission is enabled, its contents move into a shift register and go out one bit per baud tick. The baud tick is an input pulse that lasts one clock cycle. The block does not generate the baud rate.

Each frame starts with a low start bit and ends with one or two high stop bits. Between them sit 7 or 8 data bits, sent least- or most-significant first. An optional slot may follow the data. In normal mode that slot carries an even or odd parity bit. In multiprocessor mode it always carries an address/data marker bit.

The frame's data and configuration are captured when the word leaves the holding register. If the enable is dropped while a frame is in flight, the block drains the holding register before it goes quiet.

Top module: `serial_frame_tx`

## Requirements
- R1: After a synchronous active-low reset, `txd` is 1, `busy` is 0 and `hold_empty` is 1.
- R2: A frame is one start bit at 0, then data, then an optional extra bit, then stop bits at 1. There are two stop bits when `cfg_stop2`=1 and one when it is 0. The total length is 1 + data bits + extra bit (0 or 1) + stop bits.
- R3: `cfg_len8`=1 sends 8 data bits and `cfg_len8`=0 sends bits 6..0 of `wr_data`. `cfg_msb_first`=0 sends bit 0 first. `cfg_msb_first`=1 sends the highest sent bit first and bit 0 last.
- R4: In normal mode (`cfg_mp_mode`=0) with `cfg_par_en`=1, a parity bit follows the last data bit. It is computed over the sent data bits only. `cfg_par_odd`=0 gives even parity and `cfg_par_odd`=1 gives odd parity.
- R5: In multiprocessor mode (`cfg_mp_mode`=1), the slot after the data carries `cfg_adr_bit`, whatever `cfg_par_en` is.
- R6: A write (`wr_en`=1) is taken only while `hold_empty`=1, and it clears `hold_empty`. A write while `hold_empty`=0 is ignored.
- R7: With `tx_en`=1 and the holding register full while the line is idle, the word moves to the shift register and `hold_empty` returns to 1. The start bit then begins on the next tick.
- R8: With `tx_en`=0 and no frame in flight, a written word stays held and nothing is sent.
- R9: If `tx_en` falls while a frame is in flight, the block finishes that frame. It then also sends any word held at that time or written before the holding register empties, and then stops.
- R10: `busy` is 1 from the start bit through the last stop bit. Whenever `busy` is 0, `txd` is 1.
- R11: Data and configuration are captured at the transfer. Changing the configuration inputs during a frame does not alter that frame.
- R12: `txd` changes only on clock edges where `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmit enable |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity enable (normal mode) |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_msb_first | input | 1 | 1: most-significant data bit first |
| cfg_mp_mode | input | 1 | 1: multiprocessor mode |
| cfg_adr_bit | input | 1 | Address/data marker value in multiprocessor mode |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Host write data |
| hold_empty | output | 1 | Holding register empty flag |
| busy | output | 1 | Frame on the line |
| txd | output | 1 | Serial output, idles high |

## Verification
The assertions check the following on every cycle:
- the line is high whenever no frame is active;
- a frame opens with a low bit and closes on a high one;
- the line moves only on tick edges;
- a write to a full holding register leaves the held word untouched, and an accepted write clears the empty flag.

Only the bench's scenarios can show the rest:
- the bit order for each length, the parity value and the marker bit;
- the exact frame length;
- that configuration changes mid-frame have no effect;
- that a second word still leaves the line after the enable drops.

// File: rtl/sft_pkg.sv
// Shared types for the serial frame transmitter.
// Assumes nothing beyond being compiled before the modules that import it.
package sft_pkg;

    // Frame configuration, captured together with the data word at transfer
    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
        logic msb_first;
        logic mp_mode;
        logic adr_bit;
    } sft_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_SEND  = 2'd2
    } sft_state_t;

endpackage

// File: rtl/sft_hold.sv
// One-entry transmit holding register with its empty flag.
// Accepts a write only while empty; the sequencer's take pulse empties it.
// Assumes take is asserted only while the register is full.
module sft_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data
);

    logic full_q;
    logic [DATA_W-1:0] data_q;
    logic accept;

    assign accept    = wr_en && !full_q;
    assign hold_full = full_q;
    assign hold_data = data_q;

    // Purpose: track occupancy and capture accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (accept) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full_q) |=> $stable(data_q));

    // R6
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_q) |=> full_q);

endmodule

// File: rtl/sft_frame.sv
// Combinational frame builder.
// From the held word and the configuration it forms the bit vector in
// transmit order (bit 0 first): start, data, optional slot, then ones.
// It also gives the frame length in bit times. Positions past the
// length are ones, so the stop bits need no separate logic.
module sft_frame
    import sft_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  sft_cfg_t           cfg,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len
);

    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] ordered;
    logic [DATA_W-1:0] sent;
    logic              par;
    logic              slot_en;
    logic              slot_bit;

    // Purpose: mirror the word for most-significant-first order
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            rev[i] = data[DATA_W-1-i];
        end
    end

    // Purpose: choose the data order, parity and slot bit
    always_comb begin
        if (cfg.msb_first) begin
            ordered = cfg.len8 ? rev : (rev >> 1);
        end else begin
            ordered = data;
        end
        sent             = data;
        sent[DATA_W-1]   = data[DATA_W-1] & cfg.len8;
        par              = (^sent) ^ cfg.par_odd;
        slot_en          = cfg.mp_mode | cfg.par_en;
        slot_bit         = cfg.mp_mode ? cfg.adr_bit : par;
    end

    // Purpose: place the bits in transmit order and compute the length
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W - 1; i++) begin
            frame[i+1] = ordered[i];
        end
        if (cfg.len8) begin
            frame[DATA_W] = ordered[DATA_W-1];
        end
        if (slot_en) begin
            if (cfg.len8) begin
                frame[DATA_W+1] = slot_bit;
            end else begin
                frame[DATA_W] = slot_bit;
            end
        end
        len = CNT_W'(DATA_W + 1) + CNT_W'(cfg.len8) + CNT_W'(slot_en)
            + CNT_W'(cfg.stop2);
    end

endmodule

// File: rtl/sft_seq.sv
// Frame sequencer and output shift register.
// It takes the held frame when it is idle and allowed to run. It then waits
// for a tick to start and sends one bit per tick. A drain flag keeps it
// running after the enable drops, until the frame in flight and any held
// word have gone out.
// Assumes tick is a single-cycle pulse.
module sft_seq
    import sft_pkg::*;
#(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               tx_en,
    input  logic               hold_full,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   len_in,
    output logic               take,
    output logic               txd,
    output logic               busy
);

    sft_state_t         state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   len_q;
    logic [CNT_W-1:0]   left_q;
    logic               txd_q;
    logic               busy_q;
    logic               drain_q;
    logic               run;

    assign run  = tx_en || drain_q;
    assign take = (state_q == SEQ_IDLE) && hold_full && run;
    assign txd  = txd_q;
    assign busy = busy_q;

    // Purpose: keep running after the enable drops until the work is done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= 1'b0;
        end else begin
            drain_q <= !tx_en && ((state_q != SEQ_IDLE) || (drain_q && hold_full));
        end
    end

    // Purpose: step the frame through idle, armed and sending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            shreg_q <= '1;
            len_q   <= '0;
            left_q  <= '0;
            txd_q   <= 1'b1;
            busy_q  <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (take) begin
                        shreg_q <= frame_in;
                        len_q   <= len_in;
                        state_q <= SEQ_ARMED;
                    end
                end
                SEQ_ARMED: begin
                    if (tick) begin
                        txd_q   <= shreg_q[0];
                        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                        left_q  <= len_q - CNT_W'(1);
                        busy_q  <= 1'b1;
                        state_q <= SEQ_SEND;
                    end
                end
                SEQ_SEND: begin
                    if (tick) begin
                        if (left_q == '0) begin
                            txd_q   <= 1'b1;
                            busy_q  <= 1'b0;
                            state_q <= SEQ_IDLE;
                        end else begin
                            txd_q   <= shreg_q[0];
                            shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
                            left_q  <= left_q - CNT_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    // R10
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> txd_q);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> !txd_q);

    // R2
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(txd_q));

    // R12
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd_q));

endmodule

// File: rtl/serial_frame_tx.sv
// Asynchronous serial frame transmitter, top level.
// Connects the holding register, the frame builder and the sequencer.
// Assumes tick is a one-cycle pulse per bit time from an external divider.
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_msb_first,
    input  logic              cfg_mp_mode,
    input  logic              cfg_adr_bit,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hold_empty,
    output logic              busy,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    sft_cfg_t           cfg;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               take;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;

    // Purpose: gather the configuration pins into one record
    always_comb begin
        cfg.len8      = cfg_len8;
        cfg.par_en    = cfg_par_en;
        cfg.par_odd   = cfg_par_odd;
        cfg.stop2     = cfg_stop2;
        cfg.msb_first = cfg_msb_first;
        cfg.mp_mode   = cfg_mp_mode;
        cfg.adr_bit   = cfg_adr_bit;
    end

    assign hold_empty = !hold_full;

    sft_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_full (hold_full),
        .hold_data (hold_data)
    );

    sft_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
        .data  (hold_data),
        .cfg   (cfg),
        .frame (frame),
        .len   (len)
    );

    sft_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_en     (tx_en),
        .hold_full (hold_full),
        .frame_in  (frame),
        .len_in    (len),
        .take      (take),
        .txd       (txd),
        .busy      (busy)
    );

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       cfg_msb_first = 1'b0, cfg_mp_mode = 1'b0, cfg_adr_bit = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       hold_empty, busy, txd;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    serial_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_msb_first(cfg_msb_first),
        .cfg_mp_mode(cfg_mp_mode), .cfg_adr_bit(cfg_adr_bit),
        .wr_en(wr_en), .wr_data(wr_data),
        .hold_empty(hold_empty), .busy(busy), .txd(txd)
    );

    // Fields: [14:7] data, [6] len8, [5] par_en, [4] odd, [3] stop2, [2] msb, [1] mp, [0] adr
    localparam logic [14:0] VEC [8] = '{
        {8'hA5, 7'b1000000},
        {8'h3C, 7'b1101000},
        {8'h3C, 7'b1110100},
        {8'h81, 7'b0100000},
        {8'h4D, 7'b0111100},
        {8'hF0, 7'b1100011},
        {8'h12, 7'b0001110},
        {8'h00, 7'b1111100}
    };

    // tick generator, driven away from the active edge
    int tdiv = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv = 0;
            tick = 1'b0;
        end else begin
            tick = (tdiv == DIV - 1);
            tdiv = (tdiv + 1) % DIV;
        end
    end

    logic tick_hit = 1'b0;
    always @(posedge clk) tick_hit <= tick;

    // frame monitor
    logic [15:0] cap_bits = '0;
    int          cap_n = 0;
    bit          collecting = 0;
    logic [15:0] hist_bits [32];
    int          hist_len [32];
    int          frames_done = 0;
    int          glitches = 0;
    int          idle_low = 0;
    logic        prev_txd = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (txd !== prev_txd && !tick_hit) glitches++;
            if (!busy && txd !== 1'b1) idle_low++;
            if (tick_hit) begin
                if (busy) begin
                    cap_bits[cap_n] = txd;
                    cap_n++;
                    collecting = 1;
                end else if (collecting) begin
                    collecting = 0;
                    hist_bits[frames_done % 32] = cap_bits;
                    hist_len[frames_done % 32]  = cap_n;
                    frames_done++;
                    cap_bits = '0;
                    cap_n = 0;
                end
            end
        end
        prev_txd = txd;
    end

    task automatic chk(input bit ok, input string msg, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
        end
    endtask

    task automatic apply_cfg(input logic [14:0] v);
        cfg_len8 = v[6]; cfg_par_en = v[5]; cfg_par_odd = v[4]; cfg_stop2 = v[3];
        cfg_msb_first = v[2]; cfg_mp_mode = v[1]; cfg_adr_bit = v[0];
    endtask

    // expected frame from the requirements (R2 R3 R4 R5)
    task automatic exp_frame(input logic [14:0] v, output logic [15:0] bits, output int n);
        logic [7:0] d;
        int nd;
        logic p;
        d = v[14:7];
        nd = v[6] ? 8 : 7;
        bits = '0;
        n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < nd; i++) begin
            bits[n] = v[2] ? d[nd-1-i] : d[i];
            n++;
        end
        if (v[1]) begin
            bits[n] = v[0]; n++;
        end else if (v[5]) begin
            p = v[4];
            for (int i = 0; i < nd; i++) p = p ^ d[i];
            bits[n] = p; n++;
        end
        bits[n] = 1'b1; n++;
        if (v[3]) begin
            bits[n] = 1'b1; n++;
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        int lim;
        lim = 0;
        while (frames_done < target && lim < 2000) begin
            @(negedge clk);
            lim++;
        end
        chk(frames_done >= target, "watchdog frame wait", frames_done, target);
    endtask

    task automatic wait_busy();
        int lim;
        lim = 0;
        while (!busy && lim < 200) begin
            @(negedge clk);
            lim++;
        end
    endtask

    task automatic compare_frame(input int idx, input logic [14:0] v, input string tag);
        logic [15:0] eb;
        int en;
        exp_frame(v, eb, en);
        chk(hist_len[idx % 32] == en, {tag, " R2 R10 frame length"}, hist_len[idx % 32], en);
        chk(hist_bits[idx % 32] == eb, {tag, " R3 R4 R5 frame bits"}, int'(hist_bits[idx % 32]), int'(eb));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        int lat;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(txd === 1'b1, "R1 txd after reset", txd, 1);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(hold_empty === 1'b1, "R1 hold_empty after reset", hold_empty, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8 and R6: held while disabled, second write ignored
        apply_cfg(VEC[0]);
        do_write(8'h55);
        chk(hold_empty === 1'b0, "R6 write clears empty", hold_empty, 0);
        do_write(8'hAA);
        repeat (60) @(negedge clk);
        chk(frames_done == 0, "R8 nothing sent while disabled", frames_done, 0);
        chk(hold_empty === 1'b0, "R8 word still held", hold_empty, 0);
        base = frames_done;
        tx_en = 1'b1;
        wait_frames(base + 1);
        compare_frame(base, {8'h55, VEC[0][6:0]}, "R6 first write kept");

        // vector table walk: R2 R3 R4 R5
        for (int k = 0; k < 8; k++) begin
            apply_cfg(VEC[k]);
            chk(hold_empty === 1'b1, "R6 empty before write", hold_empty, 1);
            base = frames_done;
            do_write(VEC[k][14:7]);
            wait_frames(base + 1);
            compare_frame(base, VEC[k], "table");
        end

        // R7 transfer timing
        apply_cfg(VEC[1]);
        base = frames_done;
        do_write(8'h99);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R7 empty after transfer", hold_empty, 1);
        chk(busy === 1'b0, "R7 no start before tick", busy, 0);
        lat = 0;
        while (!busy && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk(lat >= 1 && lat <= DIV, "R7 start on next tick", lat, DIV);
        wait_frames(base + 1);
        compare_frame(base, {8'h99, VEC[1][6:0]}, "R7");

        // R11 configuration change mid-frame
        apply_cfg(VEC[2]);
        base = frames_done;
        do_write(VEC[2][14:7]);
        wait_busy();
        apply_cfg(VEC[6]);
        wait_frames(base + 1);
        compare_frame(base, VEC[2], "R11 latched config");

        // R9 drain after enable drops
        apply_cfg(VEC[4]);
        base = frames_done;
        do_write(8'h6B);
        wait_busy();
        do_write(8'h27);
        tx_en = 1'b0;
        wait_frames(base + 2);
        compare_frame(base, {8'h6B, VEC[4][6:0]}, "R9 frame in flight");
        compare_frame(base + 1, {8'h27, VEC[4][6:0]}, "R9 held word drained");
        repeat (DIV * 3) @(negedge clk);
        chk(busy === 1'b0, "R9 stopped after drain", busy, 0);
        chk(hold_empty === 1'b1, "R9 holding empty after drain", hold_empty, 1);

        // R8 after drain: a new word waits
        base = frames_done;
        do_write(8'h3E);
        repeat (80) @(negedge clk);
        chk(frames_done == base, "R8 no frame after stop", frames_done, base);
        chk(hold_empty === 1'b0, "R8 word held after stop", hold_empty, 0);

        // R12 and R10 line checks over the whole run
        chk(glitches == 0, "R12 txd moved without tick", glitches, 0);
        chk(idle_low == 0, "R10 line low while not busy", idle_low, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule